// File: doc/BRIEF.md
# Ethernet PHY LED behaviour controller

This block turns the live status of an Ethernet PHY into four LED drive levels. Each LED is programmed through two 8-bit registers: a primary register and a secondary register. Each register holds two 4-bit fields. Three of those fields pick a status condition for steady light, for fast blinking and for slow blinking. The fourth is a mask of activity events. When a masked event occurs, the LED goes dark for a short time, so that short traffic bursts stay visible.

Two global registers complete the set. The first sets the fast and slow blink rates, at 2, 4, 8 or 16 Hz, counted from a millisecond tick input. It also holds a 3-bit inverse-scan condition. The second holds a 3-bit scan condition and a 3-bit group-blink condition. While the group-blink condition is true, all four LEDs blink together at the slow rate. Software reaches the ten registers through a plain write/read port.

Top module: `phy_led_ctrl`

## Requirements
- R1: After reset, the registers read back as follows: rate/inverse-scan 0xC5 at address 0, scan/group-blink 0x67 at address 1, primary LED0..LED3 0x70, 0x20, 0x40, 0x40 at addresses 2..5, and secondary LED0..LED3 0x03, 0x00, 0x00, 0x20 at addresses 6..9.
- R2: A write takes effect at the next clock edge. Reserved bits read as zero: bit 3 of address 0, bits 7 and 3 of address 1, and bit 3 of each secondary register. Addresses 10..15 read as zero, and writes to them change nothing.
- R3: The 4-bit condition codes are evaluated as follows. Code 0 is never true. Codes 1..7 form a speed mask (bit0 = 10, bit1 = 100, bit2 = 1000 Mbit/s) that is true when the link is up at a selected speed. Code 8 is power-down, 9 is EEE, 0xA is auto-negotiation, 0xB is self-test and 0xC is cable diagnostics. Codes 0xD..0xF are never true. The link_speed input is coded 00 = 10, 01 = 100, 10 = 1000 and 11 = no valid speed.
- R4: The primary register holds the steady-on code in bits 7:4 and the fast-blink code in bits 3:0. The secondary register holds the slow-blink code in bits 7:4. For each LED, a true fast-blink condition outranks a true slow-blink condition, and a true slow-blink condition outranks a true steady-on condition. If none is true, the LED is off. Both blink waveforms start in their dark half after reset.
- R5: Address 0 bits 7:6 pick the fast rate and bits 5:4 pick the slow rate (00 = 2, 01 = 4, 10 = 8, 11 = 16 Hz). Each waveform has a 50% duty cycle, with half-periods of 250, 125, 62 and 31 ticks.
- R6: Bits 2:0 of the secondary register mask transmit (bit0), receive (bit1) and collision (bit2) events. A masked event darkens the LED from the next clock edge and keeps it dark for 32 ticks. A new event restarts the 32 ticks. Unmasked events have no effect.
- R7: Bits 2:0 of address 1 select the group-blink condition (0 none, 1 link up, 2 power-down, 3 EEE, 4 auto-negotiation, 5 self-test, 6 cable diagnostics, 7 test mode). While it is true, all four LEDs follow the slow blink waveform, overriding every per-LED setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| link_up | input | 1 | Link is established |
| link_speed | input | 2 | 00 = 10, 01 = 100, 10 = 1000 Mbit/s |
| pwr_down | input | 1 | PHY is powered down |
| eee_on | input | 1 | Energy-efficient mode active |
| aneg_busy | input | 1 | Auto-negotiation running |
| selftest_busy | input | 1 | Analog self-test running |
| cdiag_busy | input | 1 | Cable diagnostics running |
| test_mode | input | 1 | Test mode running |
| tx_act | input | 1 | Transmit activity pulse |
| rx_act | input | 1 | Receive activity pulse |
| col_act | input | 1 | Collision pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| led | output | 4 | LED drive levels, 1 = lit |

## Verification
Two functions can act on the same LED in the same cycle: an activity stretch and a blink or steady-on condition. The bench sets LED0 to steady-on for a 10 Mbit/s link while a masked transmit pulse lands, then runs the tick every cycle. It checks that the LED is still dark 31 ticks after the load and lit at the 32nd tick. A receive pulse then arrives partway through a stretch, and the bench judges the restarted window by the same count. Group blink is also provoked while a steady-on condition holds. The bench then measures the slow half-period on the outputs and checks that all four LEDs agree.

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl #(
  parameter int HALF_2HZ   = 250,
  parameter int STRETCH_MS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       link_up,
  input  logic [1:0] link_speed,
  input  logic       pwr_down,
  input  logic       eee_on,
  input  logic       aneg_busy,
  input  logic       selftest_busy,
  input  logic       cdiag_busy,
  input  logic       test_mode,
  input  logic       tx_act,
  input  logic       rx_act,
  input  logic       col_act,
  input  logic       reg_we,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic [3:0] led
);
  localparam int NLED = 4;
  localparam int BW = $clog2(HALF_2HZ + 1);
  localparam int SW = $clog2(STRETCH_MS + 1);
  localparam logic [31:0] PRI_RST = 32'h4040_2070;
  localparam logic [31:0] SEC_RST = 32'h2000_0003;
  localparam logic [7:0]  RATE_MASK = 8'hF7;
  localparam logic [7:0]  GRP_MASK  = 8'h77;
  localparam logic [7:0]  SEC_MASK  = 8'hF7;

  logic [7:0] rate_q, grp_q;
  logic [7:0] pri_q [NLED];
  logic [7:0] sec_q [NLED];
  logic [1:0] ph;
  logic [2:0] spd_hot;
  logic       grp_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= 8'hC5;
      grp_q  <= 8'h67;
      for (int i = 0; i < NLED; i++) begin
        pri_q[i] <= PRI_RST[8*i +: 8];
        sec_q[i] <= SEC_RST[8*i +: 8];
      end
    end else if (reg_we) begin
      if (reg_addr == 4'd0) rate_q <= reg_wdata & RATE_MASK;
      if (reg_addr == 4'd1) grp_q  <= reg_wdata & GRP_MASK;
      for (int i = 0; i < NLED; i++) begin
        if (reg_addr == 4'(2 + i)) pri_q[i] <= reg_wdata;
        if (reg_addr == 4'(2 + NLED + i)) sec_q[i] <= reg_wdata & SEC_MASK;
      end
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == 4'd0) reg_rdata = rate_q;
    if (reg_addr == 4'd1) reg_rdata = grp_q;
    for (int i = 0; i < NLED; i++) begin
      if (reg_addr == 4'(2 + i)) reg_rdata = pri_q[i];
      if (reg_addr == 4'(2 + NLED + i)) reg_rdata = sec_q[i];
    end
  end

  always_comb begin
    spd_hot = 3'b000;
    if (link_up)
      case (link_speed)
        2'b00:   spd_hot = 3'b001;
        2'b01:   spd_hot = 3'b010;
        2'b10:   spd_hot = 3'b100;
        default: spd_hot = 3'b000;
      endcase
  end

  function automatic logic cond4(input logic [3:0] c);
    case (c)
      4'h0:    cond4 = 1'b0;
      4'h8:    cond4 = pwr_down;
      4'h9:    cond4 = eee_on;
      4'hA:    cond4 = aneg_busy;
      4'hB:    cond4 = selftest_busy;
      4'hC:    cond4 = cdiag_busy;
      4'hD, 4'hE, 4'hF: cond4 = 1'b0;
      default: cond4 = |(c[2:0] & spd_hot);
    endcase
  endfunction

  always_comb begin
    case (grp_q[2:0])
      3'd1:    grp_on = link_up;
      3'd2:    grp_on = pwr_down;
      3'd3:    grp_on = eee_on;
      3'd4:    grp_on = aneg_busy;
      3'd5:    grp_on = selftest_busy;
      3'd6:    grp_on = cdiag_busy;
      3'd7:    grp_on = test_mode;
      default: grp_on = 1'b0;
    endcase
  end

  genvar g;
  for (g = 0; g < 2; g++) begin : g_blink
    logic [1:0]    sel;
    logic [BW-1:0] half, cnt;
    logic          ph_r;
    assign sel  = (g == 0) ? rate_q[7:6] : rate_q[5:4];
    assign half = BW'(HALF_2HZ >> sel);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt  <= '0;
        ph_r <= 1'b0;
      end else if (ms_tick) begin
        if (cnt >= half - 1'b1) begin
          cnt  <= '0;
          ph_r <= ~ph_r;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
    assign ph[g] = ph_r;

    a_r5_phase_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !ms_tick |=> $stable(ph_r));
  end

  for (g = 0; g < NLED; g++) begin : g_led
    logic [SW-1:0] st;
    logic          ev;
    assign ev = |(sec_q[g][2:0] & {col_act, rx_act, tx_act});
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    st <= '0;
      else if (ev)                   st <= SW'(STRETCH_MS);
      else if (ms_tick && st != '0)  st <= st - 1'b1;
    end
    assign led[g] = grp_on                  ? ph[1] :
                    (st != '0)              ? 1'b0  :
                    cond4(pri_q[g][3:0])    ? ph[0] :
                    cond4(sec_q[g][7:4])    ? ph[1] :
                    cond4(pri_q[g][7:4]);

    a_r6_event_darkens: assert property (@(posedge clk) disable iff (!rst_n)
      ev |=> (!led[g] || grp_on));
    a_r6_stretch_bound: assert property (@(posedge clk) disable iff (!rst_n)
      st <= SW'(STRETCH_MS));
    a_r2_primary_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 4'(2 + g)) |=> pri_q[g] == $past(reg_wdata));
    a_r3_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_q[g] == 8'h00 && sec_q[g][7:4] == 4'h0 && !grp_on) |-> !led[g]);
    a_r7_group_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
      grp_on |-> led[g] == led[0]);
  end

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rate_q[3] == 1'b0 && grp_q[7] == 1'b0 && grp_q[3] == 1'b0);
endmodule

// File: tb/phy_led_ctrl_test.sv
`timescale 1ns/1ps
module phy_led_ctrl_test;
  logic clk = 0, rst_n = 0, ms_tick = 0;
  logic link_up = 0, pwr_down = 0, eee_on = 0, aneg_busy = 0;
  logic selftest_busy = 0, cdiag_busy = 0, test_mode = 0;
  logic tx_act = 0, rx_act = 0, col_act = 0, reg_we = 0;
  logic [1:0] link_speed = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [3:0] led;
  int total = 0, bad = 0, meas = 0;
  bit done = 0;

  typedef struct { int kind; logic [7:0] mask; logic [7:0] exp; string tag; } item_t;
  item_t sbq[$];

  always #10 clk = ~clk;

  phy_led_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .link_up(link_up),
    .link_speed(link_speed), .pwr_down(pwr_down), .eee_on(eee_on),
    .aneg_busy(aneg_busy), .selftest_busy(selftest_busy), .cdiag_busy(cdiag_busy),
    .test_mode(test_mode), .tx_act(tx_act), .rx_act(rx_act), .col_act(col_act),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .led(led));

  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      logic [7:0] a;
      it = sbq.pop_front();
      case (it.kind)
        0:       a = {4'b0, led};
        1:       a = reg_rdata;
        default: a = meas[7:0];
      endcase
      total++;
      if ((a & it.mask) !== it.exp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, a & it.mask, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic push(int k, logic [7:0] m, logic [7:0] e, string t);
    sbq.push_back('{k, m, e, t});
    step();
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] e, string t);
    reg_addr = a;
    push(1, 8'hFF, e, t);
  endtask

  task automatic half(output int n);
    logic p;
    p = led[0];
    n = 0;
    while (led[0] == p && n < 3000) begin
      step();
      n++;
    end
  endtask

  task automatic measure(int e, string t);
    int n;
    half(n); half(n); half(n);
    meas = n;
    push(2, 8'hFF, 8'(e), t);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    // R1 reset state
    rd(0, 8'hC5, "R1 rate reg");
    rd(1, 8'h67, "R1 group reg");
    rd(2, 8'h70, "R1 pri0");  rd(3, 8'h20, "R1 pri1");
    rd(4, 8'h40, "R1 pri2");  rd(5, 8'h40, "R1 pri3");
    rd(6, 8'h03, "R1 sec0");  rd(7, 8'h00, "R1 sec1");
    rd(8, 8'h00, "R1 sec2");  rd(9, 8'h20, "R1 sec3");
    push(0, 8'h0F, 8'h0, "R1 leds dark with no status");
    // R3 speed masks with reset settings
    link_up = 1; link_speed = 2'b01;
    push(0, 8'h0F, 8'h3, "R3 link 100");
    link_speed = 2'b10;
    push(0, 8'h0F, 8'hD, "R3 link 1000");
    link_speed = 2'b00;
    push(0, 8'h0F, 8'h1, "R3 link 10");
    link_speed = 2'b11;
    push(0, 8'h0F, 8'h0, "R3 invalid speed");
    link_up = 0; link_speed = 2'b00;
    push(0, 8'h0F, 8'h0, "R3 link down");
    // R3 status codes
    wr(2, 8'hC0); wr(3, 8'h80); wr(4, 8'h90); wr(5, 8'hD0); wr(9, 8'h00);
    pwr_down = 1; eee_on = 1; cdiag_busy = 1;
    push(0, 8'h0F, 8'h7, "R3 pdown eee cdiag and code D never");
    wr(2, 8'hA0); cdiag_busy = 0; aneg_busy = 1;
    push(0, 8'h01, 8'h1, "R3 aneg code A");
    wr(2, 8'hB0); aneg_busy = 0; selftest_busy = 1;
    push(0, 8'h01, 8'h1, "R3 selftest code B");
    pwr_down = 0; eee_on = 0; selftest_busy = 0;
    push(0, 8'h0F, 8'h0, "R3 all status cleared");
    // R2 writes and reserved bits
    wr(0, 8'hFF); rd(0, 8'hF7, "R2 rate reserved bit");
    wr(1, 8'hFF); rd(1, 8'h77, "R2 group reserved bits");
    wr(6, 8'hFF); rd(6, 8'hF7, "R2 sec reserved bit");
    wr(12, 8'h55); rd(12, 8'h00, "R2 unmapped reads zero");
    rd(0, 8'hF7, "R2 unmapped write harmless");
    wr(0, 8'hC5); wr(1, 8'h00);
    // R4 slow over steady (phases still dark: no tick yet)
    wr(2, 8'h70); wr(6, 8'h20);
    link_up = 1; link_speed = 2'b01;
    push(0, 8'h01, 8'h0, "R4 slow outranks steady");
    link_speed = 2'b00;
    push(0, 8'h01, 8'h1, "R4 steady when slow false");
    // R6 stretch
    wr(6, 8'h03);
    tx_act = 1; step();
    tx_act = 0; ms_tick = 1;
    push(0, 8'h01, 8'h0, "R6 dark after tx");
    repeat (30) step();
    push(0, 8'h01, 8'h0, "R6 still dark at tick 31");
    push(0, 8'h01, 8'h1, "R6 lit after 32 ticks");
    tx_act = 1; step(); tx_act = 0;
    repeat (20) step();
    rx_act = 1; step(); rx_act = 0;
    repeat (31) step();
    push(0, 8'h01, 8'h0, "R6 retrigger extends dark");
    push(0, 8'h01, 8'h1, "R6 lit after retrigger window");
    col_act = 1; step(); col_act = 0;
    push(0, 8'h01, 8'h1, "R6 unmasked collision ignored");
    wr(6, 8'h04);
    col_act = 1; step(); col_act = 0;
    push(0, 8'h01, 8'h0, "R6 masked collision darkens");
    wr(6, 8'h08); rd(6, 8'h00, "R6 reserved mask bit reads zero");
    repeat (40) step();
    // R5 rates on fast blink
    wr(2, 8'h07); wr(6, 8'h00);
    wr(0, 8'h05); measure(250, "R5 fast 2Hz");
    wr(0, 8'h45); measure(125, "R5 fast 4Hz");
    wr(0, 8'h85); measure(62, "R5 fast 8Hz");
    wr(0, 8'hC5); measure(31, "R5 fast 16Hz");
    wr(2, 8'h00); wr(6, 8'h70);
    wr(0, 8'h15); measure(125, "R5 slow 4Hz");
    // R4 fast over slow
    wr(2, 8'h07); wr(0, 8'hC5);
    measure(31, "R4 fast outranks slow");
    // R7 group blink
    wr(2, 8'h70); wr(6, 8'h00); wr(0, 8'hE0);
    push(0, 8'h01, 8'h1, "R7 steady before group");
    wr(1, 8'h07); test_mode = 1;
    measure(62, "R7 group follows slow rate");
    step();
    meas = (led == 4'h0 || led == 4'hF) ? 1 : 0;
    push(2, 8'hFF, 8'h01, "R7 all leds in lockstep");
    test_mode = 0;
    push(0, 8'h01, 8'h1, "R7 steady after group ends");
    step();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule